// File: doc/BRIEF.md
# Laser bias startup sequencer

This block brings an optical transmitter's drive codes up from zero after power-on. It holds the modulation and bias DAC codes at zero until the power-up qualifiers arrive. The first qualifier is a finished temperature conversion. When the supply-low check is enabled, a supply conversion reading above the low threshold is also required. The block then loads the modulation code from the lookup value that the temperature reading selects. Bias bring-up follows in three phases:

- **STEP:** the bias code climbs in coarse steps until the power-feedback comparator reports that the setpoint has been passed.
- **SEARCH:** a binary search narrows the bias code between the last code below the setpoint and the first code above it.
- **INTEG:** a closed-loop integrator moves the code by one LSB per update.

The comparator is read only when an evaluate strobe arrives, and the system issues that strobe after each DAC update once the feedback has settled. The bias code never exceeds a programmable ceiling. The optical-power and bias alarms stay masked until the search has finished. The at-ceiling indication is never masked.

The state machine has five states:

- **IDLE:** the reset state. It moves to WAIT one cycle after reset is released.
- **WAIT:** moves to STEP when the start qualifiers are met, loading the modulation and bias codes.
- **STEP:** on each evaluate, it either adds one step (power below setpoint) or moves to SEARCH (power above setpoint, or the next step would pass the ceiling).
- **SEARCH:** each evaluate halves the range. The state moves to INTEG when the range is one LSB wide or narrower.
- **INTEG:** the final state. Each evaluate moves the bias code by one LSB.

The move from STEP to SEARCH goes straight on to INTEG when the new range is already that narrow.

Top module: `laser_bias_seq`

## Requirements
- R1: While reset is low, `mod_code` and `bias_code` are 0, `phase` is IDLE and `alarm_mask` is 1. One clock after reset is released, `phase` is WAIT.
- R2: In WAIT, the load happens on the clock edge where a temperature-done strobe has been seen, either earlier in WAIT or in that same cycle. When `vcclo_en` is 1, the load also needs a `vcc_done` strobe with `vcc_above`=1. A `vcc_done` strobe with `vcc_above`=0 does not qualify.
- R3: At the load, `mod_code` takes the `lut_mod` value present in that cycle. It holds that value in all later phases, whatever `lut_mod` does.
- R4: At the load, `phase` becomes STEP and `bias_code` becomes `istep`, or `bias_max` if `istep` is larger.
- R5: In STEP, an evaluate with `fb_high`=0 adds `istep` to `bias_code`, provided the sum does not exceed `bias_max`.
- R6: SEARCH starts from the range (last code below the setpoint, first code above it). The first code below is 0 when the first step already trips. Each evaluate replaces one end of the range with the probed midpoint. When the range is at most one LSB wide, `bias_code` is set to the lower end and `phase` becomes INTEG. For a comparator that trips at codes at or above T, the final code is min(T, `bias_max`) - 1.
- R7: `alm_out[i]` equals `alm_raw[i]` only in INTEG and is 0 in every other phase. Bits 0 to 3 carry high power, low power, high bias and bias-max quick trip. `alarm_mask` is 1 until INTEG is reached.
- R8: `phase` encodes IDLE=0, WAIT=1, STEP=2, SEARCH=3 and INTEG=4.
- R9: In INTEG, an evaluate with `fb_high`=1 lowers `bias_code` by 1, and one with `fb_high`=0 raises it by 1.
- R10: In INTEG, `bias_code` stays at 0 when lowered and stays at `bias_max` when raised. It never wraps.
- R11: `bias_code` never exceeds `bias_max`. When an STEP evaluate finds power below the setpoint but adding `istep` would pass `bias_max`, SEARCH starts with the range (current code, `bias_max`). `bias_at_max` is 1 exactly when `bias_code` equals `bias_max`, and it is never masked.
- R12: `fb_high` has no effect on `bias_code` in any cycle without `eval`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp_done | input | 1 | Temperature conversion finished strobe |
| vcc_done | input | 1 | Supply conversion finished strobe |
| vcc_above | input | 1 | Supply reading is above the low threshold (valid with `vcc_done`) |
| vcclo_en | input | 1 | Supply-low check enable |
| lut_mod | input | MW (8) | Modulation code looked up from the temperature reading |
| istep | input | BW (10) | Coarse bias step size (non-zero) |
| bias_max | input | BW (10) | Bias code ceiling |
| eval | input | 1 | Comparator evaluate strobe |
| fb_high | input | 1 | Feedback comparator: power at or above setpoint |
| alm_raw | input | AN (4) | Unmasked alarm inputs |
| mod_code | output | MW (8) | Modulation DAC code |
| bias_code | output | BW (10) | Bias DAC code |
| phase | output | 3 | Current phase |
| alarm_mask | output | 1 | Alarms masked |
| alm_out | output | AN (4) | Gated alarms |
| bias_at_max | output | 1 | Bias code is at the ceiling |

## Verification
Every code change is registered once. The new `bias_code`, `mod_code` and `phase` therefore appear one clock after the cycle that holds the evaluate or start strobe. `alm_out`, `alarm_mask` and `bias_at_max` follow the registered state with no extra delay. The bench drives each strobe for one cycle from a falling edge and compares the outputs at the next falling edge, after the single register update has settled. For searches, the bench derives the comparator response from its own trip threshold. It then compares the final code with min(T, ceiling) - 1, a value it computes without reference to the design.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_WAIT   = 3'd1,
        PH_STEP   = 3'd2,
        PH_SEARCH = 3'd3,
        PH_INTEG  = 3'd4
    } lbs_phase_e;
endpackage

// File: rtl/lbs_start_gate.sv
module lbs_start_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic temp_done,
    input  logic vcc_done,
    input  logic vcc_above,
    input  logic vcclo_en,
    output logic ready
);
    logic temp_seen_q;
    logic vcc_ok_q;
    logic vcc_ok_now;

    assign vcc_ok_now = vcc_done && vcc_above;

    always_ff @(posedge clk) begin
        if (!rst_n || !armed) begin
            temp_seen_q <= 1'b0;
            vcc_ok_q    <= 1'b0;
        end else begin
            if (temp_done)  temp_seen_q <= 1'b1;
            if (vcc_ok_now) vcc_ok_q    <= 1'b1;
        end
    end

    assign ready = armed && (temp_seen_q || temp_done) &&
                   (!vcclo_en || vcc_ok_q || vcc_ok_now);
endmodule

// File: rtl/lbs_range_split.sv
module lbs_range_split #(
    parameter int W = 10
) (
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic [W-1:0] mid,
    output logic         narrow
);
    logic [W:0] sum;
    logic [W:0] lo_plus;

    assign sum     = {1'b0, lo} + {1'b0, hi};
    assign mid     = sum[W:1];
    assign lo_plus = {1'b0, lo} + {{W{1'b0}}, 1'b1};
    assign narrow  = ({1'b0, hi} <= lo_plus);
endmodule

// File: rtl/lbs_alarm_gate.sv
module lbs_alarm_gate #(
    parameter int AN = 4
) (
    input  logic          open_i,
    input  logic [AN-1:0] raw,
    output logic [AN-1:0] gated
);
    for (genvar g = 0; g < AN; g++) begin : g_bit
        assign gated[g] = raw[g] & open_i;
    end
endmodule

// File: rtl/laser_bias_seq.sv
module laser_bias_seq
    import lbs_pkg::*;
#(
    parameter int BW = 10,
    parameter int MW = 8,
    parameter int AN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          temp_done,
    input  logic          vcc_done,
    input  logic          vcc_above,
    input  logic          vcclo_en,
    input  logic [MW-1:0] lut_mod,
    input  logic [BW-1:0] istep,
    input  logic [BW-1:0] bias_max,
    input  logic          eval,
    input  logic          fb_high,
    input  logic [AN-1:0] alm_raw,
    output logic [MW-1:0] mod_code,
    output logic [BW-1:0] bias_code,
    output logic [2:0]    phase,
    output logic          alarm_mask,
    output logic [AN-1:0] alm_out,
    output logic          bias_at_max
);
    localparam logic [BW-1:0] ONE = {{(BW-1){1'b0}}, 1'b1};

    lbs_phase_e    state_q, state_n;
    logic [MW-1:0] mod_q, mod_n;
    logic [BW-1:0] bias_q, bias_raw_n, bias_n;
    logic [BW-1:0] lo_q, lo_n, hi_q, hi_n;
    logic [BW-1:0] cand_lo, cand_hi, mid;
    logic          narrow, ready, enter_search;
    logic [BW:0]   step_sum;

    lbs_start_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .armed     (state_q == PH_WAIT),
        .temp_done (temp_done),
        .vcc_done  (vcc_done),
        .vcc_above (vcc_above),
        .vcclo_en  (vcclo_en),
        .ready     (ready)
    );

    lbs_range_split #(.W(BW)) u_split (
        .lo     (cand_lo),
        .hi     (cand_hi),
        .mid    (mid),
        .narrow (narrow)
    );

    lbs_alarm_gate #(.AN(AN)) u_alm (
        .open_i (state_q == PH_INTEG),
        .raw    (alm_raw),
        .gated  (alm_out)
    );

    assign step_sum = {1'b0, bias_q} + {1'b0, istep};

    // Candidate search range for this cycle
    always_comb begin
        cand_lo      = lo_q;
        cand_hi      = hi_q;
        enter_search = 1'b0;
        unique case (state_q)
            PH_STEP: begin
                if (eval) begin
                    if (fb_high) begin
                        cand_lo      = lo_q;
                        cand_hi      = bias_q;
                        enter_search = 1'b1;
                    end else if (step_sum > {1'b0, bias_max}) begin
                        cand_lo      = bias_q;
                        cand_hi      = bias_max;
                        enter_search = 1'b1;
                    end
                end
            end
            PH_SEARCH: begin
                if (eval) begin
                    enter_search = 1'b1;
                    if (fb_high) cand_hi = bias_q;
                    else         cand_lo = bias_q;
                end
            end
            default: ;
        endcase
    end

    // Next state and next codes
    always_comb begin
        state_n    = state_q;
        mod_n      = mod_q;
        bias_raw_n = bias_q;
        lo_n       = lo_q;
        hi_n       = hi_q;
        unique case (state_q)
            PH_IDLE: state_n = PH_WAIT;
            PH_WAIT: begin
                if (ready) begin
                    state_n    = PH_STEP;
                    mod_n      = lut_mod;
                    bias_raw_n = istep;
                    lo_n       = '0;
                    hi_n       = '0;
                end
            end
            PH_STEP, PH_SEARCH: begin
                if (enter_search) begin
                    lo_n = cand_lo;
                    hi_n = cand_hi;
                    if (narrow) begin
                        state_n    = PH_INTEG;
                        bias_raw_n = cand_lo;
                    end else begin
                        state_n    = PH_SEARCH;
                        bias_raw_n = mid;
                    end
                end else if (state_q == PH_STEP && eval) begin
                    lo_n       = bias_q;
                    bias_raw_n = step_sum[BW-1:0];
                end
            end
            PH_INTEG: begin
                if (eval) begin
                    if (fb_high) begin
                        if (bias_q != '0) bias_raw_n = bias_q - ONE;
                    end else if (bias_q < bias_max) begin
                        bias_raw_n = bias_q + ONE;
                    end
                end
            end
            default: state_n = PH_IDLE;
        endcase
        bias_n = (bias_raw_n > bias_max) ? bias_max : bias_raw_n;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            mod_q   <= '0;
            bias_q  <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
        end else begin
            state_q <= state_n;
            mod_q   <= mod_n;
            bias_q  <= bias_n;
            lo_q    <= lo_n;
            hi_q    <= hi_n;
        end
    end

    // Outputs
    always_comb begin
        phase       = state_q;
        mod_code    = mod_q;
        bias_code   = bias_q;
        alarm_mask  = (state_q != PH_INTEG);
        bias_at_max = (bias_q == bias_max);
    end
endmodule

// File: rtl/laser_bias_seq_chk.sv
module laser_bias_seq_chk
    import lbs_pkg::*;
#(
    parameter int BW = 10,
    parameter int MW = 8,
    parameter int AN = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          eval,
    input logic [MW-1:0] lut_mod,
    input logic [BW-1:0] bias_max,
    input logic [MW-1:0] mod_code,
    input logic [BW-1:0] bias_code,
    input logic [2:0]    phase,
    input logic [AN-1:0] alm_out
);
    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (bias_code == '0 && mod_code == '0));

    // R3
    mod_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == PH_WAIT && phase == PH_STEP) |-> mod_code == $past(lut_mod));

    // R3
    mod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) != PH_WAIT) |-> $stable(mod_code));

    // R7
    alarm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_INTEG) |-> alm_out == '0);

    // R8
    phase_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= 3'd4);

    // R9
    integ_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == PH_INTEG && $stable(bias_max)) |->
        ({1'b0, bias_code} == {1'b0, $past(bias_code)} ||
         {1'b0, bias_code} == {1'b0, $past(bias_code)} + 1'b1 ||
         {1'b0, $past(bias_code)} == {1'b0, bias_code} + 1'b1));

    // R11
    ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(bias_max) |-> bias_code <= bias_max);

    // R12
    no_eval_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(eval) && $past(phase) != PH_WAIT && $stable(bias_max)) |-> $stable(bias_code));
endmodule

bind laser_bias_seq laser_bias_seq_chk #(.BW(BW), .MW(MW), .AN(AN)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .eval      (eval),
    .lut_mod   (lut_mod),
    .bias_max  (bias_max),
    .mod_code  (mod_code),
    .bias_code (bias_code),
    .phase     (phase),
    .alm_out   (alm_out)
);

// File: tb/laser_bias_seq_tb_top.sv
`timescale 1ns/1ps
module laser_bias_seq_tb_top;
    localparam int BW = 10;
    localparam int MW = 8;
    localparam int AN = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          temp_done, vcc_done, vcc_above, vcclo_en;
    logic [MW-1:0] lut_mod;
    logic [BW-1:0] istep, bias_max;
    logic          eval, fb_high;
    logic [AN-1:0] alm_raw;
    logic [MW-1:0] mod_code;
    logic [BW-1:0] bias_code;
    logic [2:0]    phase;
    logic          alarm_mask, bias_at_max;
    logic [AN-1:0] alm_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    laser_bias_seq #(.BW(BW), .MW(MW), .AN(AN)) dut_i (
        .clk(clk), .rst_n(rst_n), .temp_done(temp_done), .vcc_done(vcc_done),
        .vcc_above(vcc_above), .vcclo_en(vcclo_en), .lut_mod(lut_mod),
        .istep(istep), .bias_max(bias_max), .eval(eval), .fb_high(fb_high),
        .alm_raw(alm_raw), .mod_code(mod_code), .bias_code(bias_code),
        .phase(phase), .alarm_mask(alarm_mask), .alm_out(alm_out),
        .bias_at_max(bias_at_max)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; temp_done = 0; vcc_done = 0; vcc_above = 0; vcclo_en = 0;
        eval = 0; fb_high = 0; alm_raw = '0; lut_mod = 8'h3C;
        istep = 10'd16; bias_max = 10'd600;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic start_load();
        temp_done = 1;
        @(negedge clk);
        temp_done = 0;
    endtask

    task automatic pulse_eval(input logic fb);
        eval = 1; fb_high = fb;
        @(negedge clk);
        eval = 0; fb_high = 0;
    endtask

    task automatic run_model(input int thr);
        for (int i = 0; i < 64 && phase != 3'd4; i++)
            pulse_eval(int'(bias_code) >= thr);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        chk("R1 mod in reset", mod_code, 0);
        chk("R1 bias in reset", bias_code, 0);
        chk("R1 mask in reset", alarm_mask, 1);
        chk("R8 IDLE=0", phase, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R8 WAIT=1 after release", phase, 1);
    endtask

    task automatic t_gate_vcc();
        do_reset();
        vcclo_en = 1; lut_mod = 8'hA5;
        start_load();
        chk("R2 temp only waits", phase, 1);
        chk("R2 mod still 0", mod_code, 0);
        vcc_done = 1; vcc_above = 0;
        @(negedge clk);
        vcc_done = 0;
        chk("R2 low supply waits", phase, 1);
        vcc_done = 1; vcc_above = 1;
        @(negedge clk);
        vcc_done = 0;
        chk("R4 STEP=2 after load", phase, 2);
        chk("R3 mod loaded", mod_code, 8'hA5);
        chk("R4 bias=istep", bias_code, 16);
        lut_mod = 8'h21;
        pulse_eval(0);
        chk("R3 mod held", mod_code, 8'hA5);
    endtask

    task automatic t_no_vcc_clamp();
        do_reset();
        istep = 10'd50; bias_max = 10'd30;
        start_load();
        chk("R2 no supply check", phase, 2);
        chk("R4 istep clamped", bias_code, 30);
        chk("R11 at max flag", bias_at_max, 1);
    endtask

    task automatic t_step_search();
        do_reset();
        alm_raw = 4'hF;
        start_load();
        fb_high = 1;
        repeat (3) @(negedge clk);
        fb_high = 0;
        chk("R12 no eval no change", bias_code, 16);
        for (int k = 2; k <= 5; k++) begin
            pulse_eval(0);
            chk("R5 step add", bias_code, 16 * k);
            chk("R7 masked in STEP", alm_out, 0);
        end
        pulse_eval(1);
        chk("R8 SEARCH=3", phase, 3);
        chk("R7 mask in SEARCH", alarm_mask, 1);
        run_model(70);
        chk("R6 search result", bias_code, 69);
        chk("R8 INTEG=4", phase, 4);
        chk("R7 alarms pass", alm_out, 15);
        chk("R7 mask off", alarm_mask, 0);
        pulse_eval(0);
        chk("R9 up one", bias_code, 70);
        pulse_eval(1);
        chk("R9 down one", bias_code, 69);
        pulse_eval(1);
        chk("R9 down again", bias_code, 68);
    endtask

    task automatic t_floor();
        do_reset();
        start_load();
        run_model(1);
        chk("R6 result at floor", bias_code, 0);
        chk("R6 phase INTEG", phase, 4);
        pulse_eval(1);
        chk("R10 hold at zero", bias_code, 0);
        pulse_eval(0);
        chk("R9 up from zero", bias_code, 1);
    endtask

    task automatic t_ceiling();
        do_reset();
        bias_max = 10'd40;
        start_load();
        pulse_eval(0);
        chk("R5 step to 32", bias_code, 32);
        pulse_eval(0);
        chk("R11 search on ceiling", phase, 3);
        chk("R11 midpoint 32..40", bias_code, 36);
        run_model(1000);
        chk("R6 ceiling result", bias_code, 39);
        chk("R11 below max flag", bias_at_max, 0);
        pulse_eval(0);
        chk("R11 reach max", bias_code, 40);
        chk("R11 at max flag", bias_at_max, 1);
        pulse_eval(0);
        chk("R10 hold at max", bias_code, 40);
    endtask

    initial begin
        rst_n = 0; temp_done = 0; vcc_done = 0; vcc_above = 0; vcclo_en = 0;
        lut_mod = '0; istep = 10'd16; bias_max = 10'd600;
        eval = 0; fb_high = 0; alm_raw = '0;
        t_reset();
        t_gate_vcc();
        t_no_vcc_clamp();
        t_step_search();
        t_floor();
        t_ceiling();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule